// File: doc/BRIEF.md
# Paired-Copy Output Drop-Out Stage

This stage sits on the output pins of a device that carries two identical copies of the same logic. It compares the two copies bit by bit. On every bit where they agree, it drives the first copy's value and holds that pin's tristate driver on. On every bit where they disagree, it turns that pin's driver off.

Two such devices are wired onto the same board trace. If an upset corrupts one copy inside one device, that device drops off the affected bits, and the healthy device keeps driving the correct value alone. No separate voter part is needed. When neither device has an upset, both drive every bit together.

The stage also raises a sticky upset flag one cycle after any bit mismatch. The flag stays set until an acknowledge input clears it, so the outside system can start a scrub-and-repair cycle.

Top module: `pair_compare_driver`

## Requirements
- R1: `oe_n[i]` is 1 (driver off) exactly when `copy_a[i]` and `copy_b[i]` differ, and 0 (driver on) when they match. This is combinational in the same cycle.
- R2: `dout[i]` equals `copy_a[i]` when the bit's copies match, and is 0 when its driver is off.
- R3: If any bit mismatches in a cycle, `upset_flag` is 1 after the next rising clock edge.
- R4: Once set, `upset_flag` stays at 1 while `flag_ack` is 0, even after the copies agree again.
- R5: If `flag_ack` is 1 and no bit mismatches, `upset_flag` is 0 after the next rising edge.
- R6: If a mismatch and `flag_ack` arrive in the same cycle, setting wins and `upset_flag` is 1 after the edge.
- R7: `rst_n` low at a rising edge clears `upset_flag`, even when a mismatch is present.
- R8: On a trace shared by two stages, each bit where at most one stage has dropped out carries the fault-free value. When neither stage has a fault, both drive the bit with equal values.
- R9: When both stages drop out on the same bit, that trace bit is undriven. The bench counts this as an unresolved case, and the count must equal the number of bits faulted in both devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| copy_a | input | W | Output of the first logic copy |
| copy_b | input | W | Output of the second logic copy |
| flag_ack | input | 1 | Clears the upset flag when no mismatch is present |
| oe_n | output | W | Per-bit active-low tristate enable |
| dout | output | W | Per-bit drive data, gated by the enable |
| upset_flag | output | 1 | Sticky flag, set by any mismatch |

## Verification
Two flag functions can act in the same cycle: a fresh mismatch setting the flag, and the acknowledge clearing it. The sweep provokes this on every step. It holds `flag_ack` high while it applies a new fault pattern to the two stages, over all data values, fault masks for device 0 and fault masks for device 1.

After the edge, the flag is judged against whether that step's own mask is non-zero:
- an old fault must be cleared;
- a fault in the current step must win over the acknowledge.

The same sweep resolves the shared trace in the bench. It checks the fault-free value on every singly-faulted bit and counts the bits where both stages have dropped out.

// File: rtl/pcd_pkg.sv
// Package pcd_pkg
// Purpose : shared encoding for the paired-copy output stage.
// Assumes : active-low enable polarity on the pad driver.
package pcd_pkg;
    typedef enum logic {
        DRIVE_ON  = 1'b0,
        DRIVE_OFF = 1'b1
    } drv_e;
endpackage

// File: rtl/agree_bit_cell.sv
// Module agree_bit_cell
// Purpose : compares one bit of the two logic copies and produces that
//           bit's pad enable and gated drive data.
// Assumes : purely combinational; the caller registers nothing here.
module agree_bit_cell
    import pcd_pkg::*;
(
    input  logic bit_a,
    input  logic bit_b,
    output logic en_n,
    output logic drv
);
    logic agree;
    drv_e state;

    // Agreement test and enable selection for this pin.
    always_comb begin
        agree = ~(bit_a ^ bit_b);
        state = agree ? DRIVE_ON : DRIVE_OFF;
        en_n  = state;
        drv   = bit_a & agree;
    end
endmodule

// File: rtl/upset_latch.sv
// Module upset_latch
// Purpose : sticky upset indicator; any mismatch sets it, and an
//           acknowledge clears it only when no new mismatch is present.
// Assumes : synchronous active-low reset; set has priority over clear.
module upset_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic any_err,
    input  logic ack,
    output logic flag
);
    // Set-dominant sticky register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (any_err)
            flag <= 1'b1;
        else if (ack)
            flag <= 1'b0;
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> flag);
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag);
    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !any_err) |=> !flag);
    // R7
    flag_rst_chk: assert property (@(posedge clk)
        !rst_n |=> !flag);
endmodule

// File: rtl/pair_compare_driver.sv
// Module pair_compare_driver
// Purpose : per-bit duplicate-and-compare pad stage. Bits whose copies
//           disagree release their driver so that a twin device on the
//           same trace drives alone; any disagreement raises a sticky flag.
// Assumes : copy_a/copy_b come from two identical logic copies in the
//           same clock domain; the pad drivers take an active-low enable.
module pair_compare_driver
    import pcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] copy_a,
    input  logic [W-1:0] copy_b,
    input  logic         flag_ack,
    output logic [W-1:0] oe_n,
    output logic [W-1:0] dout,
    output logic         upset_flag
);
    localparam int LAST = W - 1;

    logic any_err;

    // One comparison cell per output pin.
    for (genvar i = 0; i <= LAST; i++) begin : g_bit
        agree_bit_cell u_cell (
            .bit_a (copy_a[i]),
            .bit_b (copy_b[i]),
            .en_n  (oe_n[i]),
            .drv   (dout[i])
        );
    end

    // Any pin with its driver released counts as a detected upset.
    always_comb any_err = |oe_n;

    upset_latch u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_err (any_err),
        .ack     (flag_ack),
        .flag    (upset_flag)
    );

    // R2
    gated_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout & oe_n) == '0);
    // R1
    match_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_a == copy_b) |-> (oe_n == '0 && dout == copy_a));
endmodule

// File: tb/sim_pair_compare_driver.sv
module sim_pair_compare_driver;
    localparam int W     = 3;
    localparam int CLK_P = 10;
    localparam int N     = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack = 1'b0;
    logic [W-1:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
    logic [W-1:0] oe0, oe1, d0, d1;
    logic f0, f1;
    int checks = 0;
    int errors = 0;
    int floats = 0;

    always #(CLK_P/2) clk = ~clk;

    pair_compare_driver #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .copy_a(a0), .copy_b(b0),
        .flag_ack(ack), .oe_n(oe0), .dout(d0), .upset_flag(f0));
    pair_compare_driver #(.W(W)) u1 (
        .clk(clk), .rst_n(rst_n), .copy_a(a1), .copy_b(b1),
        .flag_ack(ack), .oe_n(oe1), .dout(d1), .upset_flag(f1));

    task automatic chk(input bit ok, input string req,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Resolves the shared trace and checks it against the fault-free value.
    task automatic check_bus(input logic [W-1:0] good, input int exp_float);
        int nfl = 0;
        for (int i = 0; i < W; i++) begin
            if (oe0[i] && oe1[i]) begin
                nfl++;
            end else if (!oe0[i] && !oe1[i]) begin
                chk(d0[i] == d1[i] && d0[i] == good[i], "R8 both drive",
                    {d0[i], d1[i]}, {good[i], good[i]});
            end else begin
                chk((oe0[i] ? d1[i] : d0[i]) == good[i], "R8 single drive",
                    oe0[i] ? d1[i] : d0[i], good[i]);
            end
        end
        floats += nfl;
        chk(nfl == exp_float, "R9 unresolved count", nfl, exp_float);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset with a mismatch present: flag must stay clear (R7).
        a0 = 3'b101;
        @(negedge clk); @(negedge clk);
        chk(f0 == 1'b0, "R7 reset clears flag", f0, 0);
        a0 = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(f0 == 1'b0 && f1 == 1'b0, "R7 flag idle after reset", f0, 0);

        // Exhaustive sweep; ack held high, so set-vs-clear meets every step.
        for (int v = 0; v < N; v++) begin
            for (int m0 = 0; m0 < N; m0++) begin
                for (int m1 = 0; m1 < N; m1++) begin
                    @(negedge clk);
                    a0 = W'(v); b0 = W'(v ^ m0);
                    a1 = W'(v ^ m1); b1 = W'(v);
                    ack = 1'b1;
                    #1;
                    chk(oe0 == W'(m0), "R1 enable dev0", oe0, m0);
                    chk(oe1 == W'(m1), "R1 enable dev1", oe1, m1);
                    chk(d0 == W'(v & ~m0), "R2 data dev0", d0, v & ~m0);
                    chk(d1 == W'(v & ~m1), "R2 data dev1", d1, v & ~m1);
                    check_bus(W'(v), $countones(W'(m0 & m1)));
                    @(negedge clk);
                    // R3 / R5 / R6: flag follows this step's own mask.
                    chk(f0 == (m0 != 0), "R6 set beats ack dev0", f0, m0 != 0);
                    chk(f1 == (m1 != 0), "R6 set beats ack dev1", f1, m1 != 0);
                end
            end
        end

        // R4: sticky with ack low after the fault goes away.
        @(negedge clk);
        ack = 1'b0; a0 = 3'b000; b0 = 3'b010; a1 = '0; b1 = '0;
        @(negedge clk);
        chk(f0 == 1'b1, "R3 flag set", f0, 1);
        b0 = 3'b000;
        @(negedge clk); @(negedge clk);
        chk(f0 == 1'b1, "R4 flag holds", f0, 1);
        ack = 1'b1;
        @(negedge clk);
        chk(f0 == 1'b0, "R5 ack clears", f0, 0);
        ack = 1'b0;

        $display("unresolved trace bits seen: %0d", floats);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule